// File: doc/BRIEF.md
# IDE PIO Cycle Timing Engine

This block times programmed-I/O read and write cycles for the two drives that share one IDE channel, and it runs on the bus clock. Each drive has its own bank with two 8-bit timing words, one for reads and one for writes. A timing word holds the length of the strobe pulse and the length of the recovery gap that follows it. The channel also has one shared configuration byte. That byte sets the address-setup length for both drives, the drive-ready sample delay and the read-prefetch enable. A requester presents a drive select and a direction. The engine then holds the address for the setup time, pulses the matching strobe, waits out the recovery time and raises a done pulse for one clock.

A combinational converter sits beside the engine. It turns nanosecond targets for setup, active pulse and full cycle into clock counts at the configured bus frequency. It clamps each count to the range the hardware can hold and encodes the result as a timing word. Address setup is shared by both drives, so the converter reports the larger of the two setup needs as the shared setup field.

Top module: `ide_pio_timing`

## Requirements
- R1: The active-pulse count is timing-word bits 7:4 plus 1 (1 to 16 clocks). The recovery count is bits 3:0 plus 2 (2 to 17 clocks).
- R2: Every cycle of either drive holds an address-setup phase with no strobe. This phase lasts config bits 5:4 plus 1 clocks (1 to 4).
- R3: Drive select 0 uses bank 0 and select 1 uses bank 1. A write (req_write=1) uses the bank's write word and a read uses its read word. cyc_drive shows the selected drive while the cycle runs.
- R4: A cycle runs in a fixed order: setup, then the strobe asserted for the active count, then the strobe low for the recovery count, then cyc_done high for exactly one clock. rd_strobe is used for reads and wr_strobe for writes, and the two are never high together.
- R5: req_ready is high only when the engine is idle. A request raised while a cycle runs is not accepted and starts no cycle. The next cycle starts only after done.
- R6: The converter computes setup and active clocks as ceil(ns*MHz/1000). Setup is clamped to 1..4 and active to 1..16.
- R7: Recovery clocks are ceil((cycle-setup-active)*MHz/1000), clamped to 2..17. A zero or negative difference gives 2.
- R8: A drive marked absent gets the minimal values: setup 1, active 1, recovery 2 (timing word 0x00).
- R9: The converter's shared setup field equals the larger of the two drives' setup clocks minus 1.
- R10: cyc_prefetch is high only while rd_strobe is high and config bit 6 is set. It is never high during a write.
- R11: drdy_clks equals config bits 2:1 plus 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_word0 | input | 8 | Drive 0 read timing word |
| wr_word0 | input | 8 | Drive 0 write timing word |
| rd_word1 | input | 8 | Drive 1 read timing word |
| wr_word1 | input | 8 | Drive 1 write timing word |
| chan_cfg | input | 8 | Shared byte: bit 6 prefetch, 5:4 setup-1, 2:1 drive-ready-2 |
| req_valid | input | 1 | Cycle request |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_drive | input | 1 | Drive select |
| req_ready | output | 1 | Engine idle, request accepted |
| rd_strobe | output | 1 | Read strobe (active high) |
| wr_strobe | output | 1 | Write strobe (active high) |
| cyc_busy | output | 1 | Setup, active or recovery phase in progress |
| cyc_drive | output | 1 | Drive selected by the running cycle |
| cyc_done | output | 1 | One-clock end-of-cycle pulse |
| cyc_prefetch | output | 1 | Read-prefetch hint during read strobe |
| drdy_clks | output | 3 | Decoded drive-ready sample delay in clocks |
| cv_present | input | 2 | Converter: drive present flags, bit n for drive n |
| cv_setup_ns0 | input | 10 | Converter: drive 0 setup target in ns |
| cv_active_ns0 | input | 10 | Converter: drive 0 active target in ns |
| cv_cycle_ns0 | input | 10 | Converter: drive 0 full-cycle target in ns |
| cv_setup_ns1 | input | 10 | Converter: drive 1 setup target in ns |
| cv_active_ns1 | input | 10 | Converter: drive 1 active target in ns |
| cv_cycle_ns1 | input | 10 | Converter: drive 1 full-cycle target in ns |
| cv_word0 | output | 8 | Converter: encoded drive 0 timing word |
| cv_word1 | output | 8 | Converter: encoded drive 1 timing word |
| cv_setup_field | output | 2 | Converter: shared setup field (max setup - 1) |

## Verification
The assertions check the following on every clock:
- The two strobes are never high together.
- cyc_done lasts one clock, comes straight after recovery and returns the engine to idle.
- req_ready never coexists with a running phase.
- The selected drive stays stable through a cycle.
- The prefetch hint is never high outside a read strobe.

Only the bench's scenarios can show the rest:
- The phase lengths measured at the pins for each bank and direction.
- That a request raised mid-cycle leaves no trace.
- The converter's rounding, clamping, absent-drive and shared-setup results for chosen nanosecond targets.

// File: rtl/ide_tmg_pkg.sv
package ide_tmg_pkg;

   localparam int SETUP_MIN = 1;
   localparam int SETUP_MAX = 4;
   localparam int ACT_MIN   = 1;
   localparam int ACT_MAX   = 16;
   localparam int REC_MIN   = 2;
   localparam int REC_MAX   = 17;
   localparam int CNT_W     = $clog2(REC_MAX + 1);
   localparam int DRDY_BASE = 2;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_SETUP,
      PH_ACTIVE,
      PH_RECOV,
      PH_DONE
   } phase_e;

   typedef struct packed {
      logic [3:0] act_m1;
      logic [3:0] rec_m2;
   } tword_t;

endpackage

// File: rtl/ide_ns2clk.sv
module ide_ns2clk
   import ide_tmg_pkg::*;
#(
   parameter int CLK_MHZ = 33,
   parameter int NS_W    = 10
) (
   input  logic            present,
   input  logic [NS_W-1:0] setup_ns,
   input  logic [NS_W-1:0] active_ns,
   input  logic [NS_W-1:0] cycle_ns,
   output logic [2:0]      setup_clk,
   output logic [7:0]      word
);

   localparam int MHZ_W  = $clog2(CLK_MHZ + 1);
   localparam int PROD_W = NS_W + MHZ_W + 2;

   if (PROD_W < 11) begin : g_bad_width
      $error("ide_ns2clk: NS_W too small for rounding constants");
   end

   function automatic logic [PROD_W-1:0] to_clk(input logic [PROD_W-1:0] ns);
      return (ns * PROD_W'(CLK_MHZ) + PROD_W'(999)) / PROD_W'(1000);
   endfunction

   function automatic logic [4:0] clampc(input logic [PROD_W-1:0] v, input int lo, input int hi);
      if (v < PROD_W'(lo))      return 5'(lo);
      else if (v > PROD_W'(hi)) return 5'(hi);
      else                      return v[4:0];
   endfunction

   logic [PROD_W-1:0] sum_ns, gap_ns;
   logic [4:0]        s_c, a_c, r_c;
   tword_t            tw;

   always_comb begin
      sum_ns = PROD_W'(setup_ns) + PROD_W'(active_ns);
      gap_ns = (PROD_W'(cycle_ns) > sum_ns) ? PROD_W'(cycle_ns) - sum_ns : '0;
      if (present) begin
         s_c = clampc(to_clk(PROD_W'(setup_ns)), SETUP_MIN, SETUP_MAX);
         a_c = clampc(to_clk(PROD_W'(active_ns)), ACT_MIN, ACT_MAX);
         r_c = clampc(to_clk(gap_ns), REC_MIN, REC_MAX);
      end else begin
         s_c = 5'(SETUP_MIN);
         a_c = 5'(ACT_MIN);
         r_c = 5'(REC_MIN);
      end
      tw.act_m1 = 4'(a_c - 5'(ACT_MIN));
      tw.rec_m2 = 4'(r_c - 5'(REC_MIN));
   end

   assign setup_clk = s_c[2:0];
   assign word      = tw;

   always_comb begin
      AST_SETUP_IN_RANGE: assert (setup_clk >= 3'(SETUP_MIN) && setup_clk <= 3'(SETUP_MAX) || $isunknown(setup_clk)); // R6
   end

endmodule

// File: rtl/ide_tmg_sel.sv
module ide_tmg_sel
   import ide_tmg_pkg::*;
#(
   parameter int NDRV = 2
) (
   input  logic [NDRV-1:0][7:0] rd_words,
   input  logic [NDRV-1:0][7:0] wr_words,
   input  logic                 sel_write,
   input  logic [$clog2(NDRV)-1:0] sel_drive,
   output logic [7:0]           word
);

   logic [NDRV-1:0][7:0] dir_words;

   for (genvar d = 0; d < NDRV; d++) begin : g_dir
      assign dir_words[d] = sel_write ? wr_words[d] : rd_words[d];
   end

   assign word = dir_words[sel_drive];

endmodule

// File: rtl/ide_cycle_fsm.sv
module ide_cycle_fsm
   import ide_tmg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic       req_write,
   input  logic       req_drive,
   input  logic [7:0] sel_word,
   input  logic [1:0] setup_field,
   output logic       req_ready,
   output logic       rd_strobe,
   output logic       wr_strobe,
   output logic       cyc_busy,
   output logic       cyc_drive,
   output logic       cyc_done
);

   phase_e           state;
   logic [CNT_W-1:0] cnt;
   logic             lat_write;
   tword_t           lat_tw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= PH_IDLE;
         cnt       <= '0;
         lat_write <= 1'b0;
         cyc_drive <= 1'b0;
         lat_tw    <= '0;
      end else begin
         case (state)
            PH_IDLE: if (req_valid) begin
               lat_write <= req_write;
               cyc_drive <= req_drive;
               lat_tw    <= sel_word;
               cnt       <= CNT_W'(setup_field);
               state     <= PH_SETUP;
            end
            PH_SETUP: if (cnt == '0) begin
               cnt   <= CNT_W'(lat_tw.act_m1);
               state <= PH_ACTIVE;
            end else begin
               cnt <= cnt - 1'b1;
            end
            PH_ACTIVE: if (cnt == '0) begin
               cnt   <= CNT_W'(lat_tw.rec_m2) + CNT_W'(1);
               state <= PH_RECOV;
            end else begin
               cnt <= cnt - 1'b1;
            end
            PH_RECOV: if (cnt == '0) begin
               state <= PH_DONE;
            end else begin
               cnt <= cnt - 1'b1;
            end
            PH_DONE: state <= PH_IDLE;
            default: state <= PH_IDLE;
         endcase
      end
   end

   assign req_ready = (state == PH_IDLE);
   assign cyc_done  = (state == PH_DONE);
   assign cyc_busy  = (state == PH_SETUP) || (state == PH_ACTIVE) || (state == PH_RECOV);
   assign rd_strobe = (state == PH_ACTIVE) && !lat_write;
   assign wr_strobe = (state == PH_ACTIVE) && lat_write;

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_strobe && wr_strobe)); // R4
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_done |=> !cyc_done && req_ready); // R4
   AST_DONE_AFTER_RECOV: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cyc_done) |-> $past(state) == PH_RECOV); // R4
   AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !cyc_busy && !rd_strobe && !wr_strobe); // R5
   AST_DRIVE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_busy && $past(cyc_busy) |-> $stable(cyc_drive)); // R3
   AST_STROBE_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_strobe || wr_strobe) |-> $past(state) == PH_SETUP); // R2

endmodule

// File: rtl/ide_pio_timing.sv
module ide_pio_timing
   import ide_tmg_pkg::*;
#(
   parameter int CLK_MHZ = 33,
   parameter int NS_W    = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [7:0]      rd_word0,
   input  logic [7:0]      wr_word0,
   input  logic [7:0]      rd_word1,
   input  logic [7:0]      wr_word1,
   input  logic [7:0]      chan_cfg,
   input  logic            req_valid,
   input  logic            req_write,
   input  logic            req_drive,
   output logic            req_ready,
   output logic            rd_strobe,
   output logic            wr_strobe,
   output logic            cyc_busy,
   output logic            cyc_drive,
   output logic            cyc_done,
   output logic            cyc_prefetch,
   output logic [2:0]      drdy_clks,
   input  logic [1:0]      cv_present,
   input  logic [NS_W-1:0] cv_setup_ns0,
   input  logic [NS_W-1:0] cv_active_ns0,
   input  logic [NS_W-1:0] cv_cycle_ns0,
   input  logic [NS_W-1:0] cv_setup_ns1,
   input  logic [NS_W-1:0] cv_active_ns1,
   input  logic [NS_W-1:0] cv_cycle_ns1,
   output logic [7:0]      cv_word0,
   output logic [7:0]      cv_word1,
   output logic [1:0]      cv_setup_field
);

   localparam int NDRV = 2;

   if (CLK_MHZ < 1 || CLK_MHZ > 1000) begin : g_bad_clk
      $error("ide_pio_timing: CLK_MHZ out of range");
   end

   logic [NDRV-1:0][7:0] rd_words, wr_words;
   logic [7:0]           sel_word;
   logic                 pf_en;

   assign rd_words  = {rd_word1, rd_word0};
   assign wr_words  = {wr_word1, wr_word0};
   assign pf_en     = chan_cfg[6];
   assign drdy_clks = 3'(chan_cfg[2:1]) + 3'(DRDY_BASE);

   ide_tmg_sel #(.NDRV(NDRV)) u_sel (
      .rd_words  (rd_words),
      .wr_words  (wr_words),
      .sel_write (req_write),
      .sel_drive (req_drive),
      .word      (sel_word)
   );

   ide_cycle_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_write   (req_write),
      .req_drive   (req_drive),
      .sel_word    (sel_word),
      .setup_field (chan_cfg[5:4]),
      .req_ready   (req_ready),
      .rd_strobe   (rd_strobe),
      .wr_strobe   (wr_strobe),
      .cyc_busy    (cyc_busy),
      .cyc_drive   (cyc_drive),
      .cyc_done    (cyc_done)
   );

   assign cyc_prefetch = rd_strobe && pf_en;

   AST_PF_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_prefetch |-> rd_strobe && !wr_strobe); // R10

   logic [NDRV-1:0][NS_W-1:0] s_ns, a_ns, c_ns;
   logic [NDRV-1:0][2:0]      s_clk;
   logic [NDRV-1:0][7:0]      words;

   assign s_ns = {cv_setup_ns1, cv_setup_ns0};
   assign a_ns = {cv_active_ns1, cv_active_ns0};
   assign c_ns = {cv_cycle_ns1, cv_cycle_ns0};

   for (genvar d = 0; d < NDRV; d++) begin : g_cvt
      ide_ns2clk #(.CLK_MHZ(CLK_MHZ), .NS_W(NS_W)) u_cvt (
         .present   (cv_present[d]),
         .setup_ns  (s_ns[d]),
         .active_ns (a_ns[d]),
         .cycle_ns  (c_ns[d]),
         .setup_clk (s_clk[d]),
         .word      (words[d])
      );
   end

   logic [2:0] s_max;
   assign s_max          = (s_clk[0] > s_clk[1]) ? s_clk[0] : s_clk[1];
   assign cv_setup_field = 2'(s_max - 3'(SETUP_MIN));
   assign cv_word0       = words[0];
   assign cv_word1       = words[1];

endmodule

// File: tb/tb_ide_pio_timing.sv
module tb_ide_pio_timing;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] rd_word0 = 8'h00, wr_word0 = 8'h00, rd_word1 = 8'h00, wr_word1 = 8'h00;
   logic [7:0] chan_cfg = 8'h00;
   logic       req_valid = 1'b0, req_write = 1'b0, req_drive = 1'b0;
   logic       req_ready, rd_strobe, wr_strobe, cyc_busy, cyc_drive, cyc_done, cyc_prefetch;
   logic [2:0] drdy_clks;
   logic [1:0] cv_present = 2'b11;
   logic [9:0] cv_setup_ns0 = '0, cv_active_ns0 = '0, cv_cycle_ns0 = '0;
   logic [9:0] cv_setup_ns1 = '0, cv_active_ns1 = '0, cv_cycle_ns1 = '0;
   logic [7:0] cv_word0, cv_word1;
   logic [1:0] cv_setup_field;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   ide_pio_timing #(.CLK_MHZ(125), .NS_W(10)) dut (
      .clk, .rst_n, .rd_word0, .wr_word0, .rd_word1, .wr_word1, .chan_cfg,
      .req_valid, .req_write, .req_drive, .req_ready, .rd_strobe, .wr_strobe,
      .cyc_busy, .cyc_drive, .cyc_done, .cyc_prefetch, .drdy_clks,
      .cv_present, .cv_setup_ns0, .cv_active_ns0, .cv_cycle_ns0,
      .cv_setup_ns1, .cv_active_ns1, .cv_cycle_ns1,
      .cv_word0, .cv_word1, .cv_setup_field
   );

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Issue one cycle and measure its phases at the pins; optionally raise a
   // stray request mid-cycle (poke) that must be ignored.
   task automatic run_cycle(input logic drv, input logic wr, input int es, input int ea,
                            input int er, input logic exp_pf, input logic poke, input string tag);
      int s = 0, a = 0, r = 0, wrong = 0, pf_bad = 0, drv_bad = 0, dn = 0, n = 0;
      @(negedge clk);
      chk(req_ready, {tag, " R5 ready when idle"}, req_ready, 1);
      req_valid = 1'b1; req_write = wr; req_drive = drv;
      @(negedge clk);
      req_valid = 1'b0; req_write = ~wr; req_drive = ~drv;
      while (n < 100) begin
         if (poke && n == 1) begin
            chk(!req_ready, {tag, " R5 not ready while busy"}, req_ready, 0);
            req_valid = 1'b1;
         end else begin
            req_valid = 1'b0;
         end
         if (cyc_done) begin dn = 1; break; end
         if ((wr ? rd_strobe : wr_strobe)) wrong++;
         if (cyc_drive != drv) drv_bad++;
         if (rd_strobe || wr_strobe) begin
            a++;
            if (cyc_prefetch != exp_pf) pf_bad++;
         end else if (a == 0) s++;
         else r++;
         if (!(rd_strobe || wr_strobe) && cyc_prefetch) pf_bad++;
         n++;
         @(negedge clk);
      end
      req_valid = 1'b0;
      chk(dn == 1, {tag, " R4 done reached"}, dn, 1);
      chk(s == es, {tag, " R2 setup clocks"}, s, es);
      chk(a == ea, {tag, " R1 active clocks"}, a, ea);
      chk(r == er, {tag, " R1 recovery clocks"}, r, er);
      chk(wrong == 0, {tag, " R4 wrong strobe"}, wrong, 0);
      chk(drv_bad == 0, {tag, " R3 drive select"}, drv_bad, 0);
      chk(pf_bad == 0, {tag, " R10 prefetch"}, pf_bad, 0);
      @(negedge clk);
      chk(!cyc_done && req_ready, {tag, " R4 done one clock"}, cyc_done, 0);
      if (poke) begin
         int busy_seen = 0;
         for (int i = 0; i < 6; i++) begin
            if (cyc_busy || rd_strobe || wr_strobe) busy_seen++;
            @(negedge clk);
         end
         chk(busy_seen == 0, {tag, " R5 stray request ignored"}, busy_seen, 0);
      end
   endtask

   task automatic test_reset();
      @(negedge clk);
      chk(req_ready && !cyc_busy && !rd_strobe && !wr_strobe && !cyc_done,
          "reset R5 idle outputs", {req_ready, cyc_busy, rd_strobe, wr_strobe}, 8);
   endtask

   task automatic test_cycles();
      rd_word0 = 8'h21; wr_word0 = 8'h52; rd_word1 = 8'h00; wr_word1 = 8'hF3;
      chan_cfg = 8'h56;
      #1 chk(drdy_clks == 3'd5, "R11 drdy decode 5", drdy_clks, 5);
      run_cycle(1'b0, 1'b0, 2, 3, 3, 1'b1, 1'b0, "rd0");
      run_cycle(1'b0, 1'b1, 2, 6, 4, 1'b0, 1'b0, "wr0");
      chan_cfg = 8'h30;
      run_cycle(1'b1, 1'b0, 4, 1, 2, 1'b0, 1'b0, "rd1");
      chan_cfg = 8'h00;
      #1 chk(drdy_clks == 3'd2, "R11 drdy decode 2", drdy_clks, 2);
      run_cycle(1'b1, 1'b1, 1, 16, 5, 1'b0, 1'b0, "wr1");
   endtask

   task automatic test_busy_ignore();
      chan_cfg = 8'h56;
      run_cycle(1'b0, 1'b0, 2, 3, 3, 1'b1, 1'b1, "busy");
   endtask

   task automatic test_convert();
      cv_present = 2'b11;
      cv_setup_ns0 = 10'd70; cv_active_ns0 = 10'd165; cv_cycle_ns0 = 10'd600;
      cv_setup_ns1 = 10'd30; cv_active_ns1 = 10'd80;  cv_cycle_ns1 = 10'd180;
      #1;
      chk(cv_word0 == 8'hFF, "R6 R7 upper clamps word0", cv_word0, 8'hFF);
      chk(cv_word1 == 8'h97, "R6 R7 rounding word1", cv_word1, 8'h97);
      chk(cv_setup_field == 2'd3, "R9 shared setup 4", cv_setup_field, 3);
      cv_setup_ns0 = 10'd5;  cv_active_ns0 = 10'd8; cv_cycle_ns0 = 10'd20;
      cv_setup_ns1 = 10'd20; cv_active_ns1 = 10'd8; cv_cycle_ns1 = 10'd20;
      #1;
      chk(cv_word0 == 8'h00, "R7 recovery floor word0", cv_word0, 0);
      chk(cv_word1 == 8'h00, "R7 negative gap word1", cv_word1, 0);
      chk(cv_setup_field == 2'd2, "R9 larger setup drive1", cv_setup_field, 2);
      cv_present = 2'b01;
      cv_setup_ns0 = 10'd0; cv_active_ns0 = 10'd40; cv_cycle_ns0 = 10'd100;
      cv_setup_ns1 = 10'd900; cv_active_ns1 = 10'd900; cv_cycle_ns1 = 10'd1000;
      #1;
      chk(cv_word0 == 8'h46, "R6 low setup clamp word0", cv_word0, 8'h46);
      chk(cv_word1 == 8'h00, "R8 absent drive word", cv_word1, 0);
      chk(cv_setup_field == 2'd0, "R8 R9 absent setup 1", cv_setup_field, 0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      test_reset();
      test_cycles();
      test_busy_ignore();
      test_convert();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule